// File: doc/BRIEF.md
# Step-Scaled Complex Divider

This block forms the quotient of two complex numbers, X = a + jb over Y = c + jd, and scales the result by an adaptation step size μ. It is the division term of a constant-modulus beam-steering update. All operands are signed 1.15 fixed point. The block does not divide. It multiplies X by the conjugate of Y and then scales the two cross sums by a factor e = μ/|Y|². That factor comes from a table built in the HDL. The caller supplies |Y|² alongside the operands.

The factor 1/|Y|² has no 1.15 representation for |Y|² in [0,1). The step size μ is therefore folded into each table entry. Entries stay below one wherever |Y|² ≥ μ. The smallest few indices clip to the largest positive code.

Operation is a fully pipelined stream with one input per cycle allowed. The table read takes two registered cycles and runs alongside the four cross products and their sums. A third stage performs the two scaling multiplies.

Top module: `mu_cdiv`

## Requirements
- R1: In each result, q_re equals clip(floor(clip(floor((a·c + b·d) / 2^15)) · e / 2^15)), where clip limits a value to [-32768, 32767] and floor rounds toward minus infinity.
- R2: In each result, q_im equals clip(floor(clip(floor((b·c − a·d) / 2^15)) · e / 2^15)), using the same clip and floor as R1.
- R3: out_valid is high in exactly those cycles that come three rising edges after a rising edge that sampled in_valid high. An input may be accepted on every cycle.
- R4: Table entry k (k = 1..511) holds floor(MU·512 / k), capped at 32767. MU is μ in 1.15 and defaults to 164 (about 0.005).
- R5: With the default MU, entries 0, 1 and 2 all hold 32767, and entry 3 is the first that is not clipped (27989).
- R6: The table index is bits [14:6] of y_pow. A y_pow with bit 15 set (negative) selects entry 0, and the low six bits do not affect the index.
- R7: Each cross sum is clipped to [-32768, 32767] before scaling. For example, a = b = c = d = −32768 gives a real cross sum of 32767.
- R8: While rst_n is low, out_valid, q_re and q_im are all 0.
- R9: q_re and q_im keep their previous values in every cycle in which out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operands on this cycle are to be processed |
| x_re | input | 16 | Numerator real part a, 1.15 |
| x_im | input | 16 | Numerator imaginary part b, 1.15 |
| y_re | input | 16 | Denominator real part c, 1.15 |
| y_im | input | 16 | Denominator imaginary part d, 1.15 |
| y_pow | input | 16 | Caller-computed \|Y\|², 1.15 |
| out_valid | output | 1 | Result on q_re/q_im is new this cycle |
| q_re | output | 16 | Real part of μ·X/Y, 1.15 |
| q_im | output | 16 | Imaginary part of μ·X/Y, 1.15 |

## Verification
The bench sweeps all 512 table indices with a numerator and denominator whose real cross sum clips to 32767. This makes each result read back as e − 1. An off-by-one index or a wrong clipping threshold would shift the result of that sweep. Negative y_pow values, and y_pow values with the low bits set, are fed in as well. A design that used the sign bit in the index, or that rounded the index, would then pick a different entry. All-minus-full-scale operands are driven to force both cross sums into positive and negative clipping. A design that wraps instead of clipping would flip the sign of the result. Random operands with random idle gaps test the fixed three-cycle latency and show whether the outputs hold between results.

// File: rtl/cdiv_pkg.sv
package cdiv_pkg;

    parameter int unsigned CD_W    = 16;
    parameter int unsigned CD_IDXW = 9;
    parameter int unsigned CD_MU   = 164;

    // Arithmetic right shift followed by clipping to a signed w-bit range.
    function automatic logic signed [63:0] clip_shr(
        input logic signed [63:0] v,
        input int unsigned        sh,
        input int unsigned        w
    );
        logic signed [63:0] s;
        logic signed [63:0] hi;
        logic signed [63:0] lo;
        s  = v >>> sh;
        hi = (64'sd1 <<< (w - 1)) - 64'sd1;
        lo = -(64'sd1 <<< (w - 1));
        if (s > hi) begin
            return hi;
        end
        if (s < lo) begin
            return lo;
        end
        return s;
    endfunction

endpackage

// File: rtl/cdiv_recip_rom.sv
module cdiv_recip_rom #(
    parameter int unsigned W    = cdiv_pkg::CD_W,
    parameter int unsigned IDXW = cdiv_pkg::CD_IDXW,
    parameter int unsigned MU   = cdiv_pkg::CD_MU
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pow_in,
    output logic [W-1:0] scale_out
);
    localparam int unsigned DEPTH  = 1 << IDXW;
    localparam int unsigned LOW_W  = W - 1 - IDXW;
    localparam longint      MAXPOS = (64'sd1 <<< (W - 1)) - 64'sd1;

    function automatic logic [W-1:0] entry_f(input int k);
        longint num;
        longint q;
        num = longint'(MU) << IDXW;
        if (k == 0) begin
            return W'(MAXPOS);
        end
        q = num / longint'(k);
        if (q > MAXPOS) begin
            return W'(MAXPOS);
        end
        return W'(q);
    endfunction

    logic [W-1:0]    tbl [DEPTH];
    logic [IDXW-1:0] idx_d;
    logic [IDXW-1:0] idx_q;

    for (genvar k = 0; k < DEPTH; k++) begin : g_ent
        localparam logic [W-1:0] ENTRY = entry_f(k);
        assign tbl[k] = ENTRY;
    end

    if (LOW_W > 0) begin : g_low
        logic unused_low;
        assign unused_low = ^pow_in[LOW_W-1:0];
    end

    // Negative power (sign bit set) maps onto the first entry.
    always_comb begin
        if (pow_in[W-1]) begin
            idx_d = '0;
        end else begin
            idx_d = pow_in[W-2 -: IDXW];
        end
    end

    // Lookup cycle one: register the address. Cycle two: register the data.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            scale_out <= '0;
        end else begin
            idx_q     <= idx_d;
            scale_out <= tbl[idx_q];
        end
    end

endmodule

// File: rtl/cdiv_cross.sv
module cdiv_cross #(
    parameter int unsigned W = cdiv_pkg::CD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                v_in,
    input  logic signed [W-1:0] a,
    input  logic signed [W-1:0] b,
    input  logic signed [W-1:0] c,
    input  logic signed [W-1:0] d,
    output logic                v_out,
    output logic signed [W-1:0] sum_re,
    output logic signed [W-1:0] sum_im
);
    localparam int unsigned PW = 2 * W;

    logic signed [PW-1:0] ax, bx, cx, dx;
    logic signed [PW-1:0] p_ac, p_bd, p_bc, p_ad;
    logic                 v1;

    assign ax = {{W{a[W-1]}}, a};
    assign bx = {{W{b[W-1]}}, b};
    assign cx = {{W{c[W-1]}}, c};
    assign dx = {{W{d[W-1]}}, d};

    // Stage 1: four cross products at full precision.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v1   <= 1'b0;
            p_ac <= '0;
            p_bd <= '0;
            p_bc <= '0;
            p_ad <= '0;
        end else begin
            v1 <= v_in;
            if (v_in) begin
                p_ac <= ax * cx;
                p_bd <= bx * dx;
                p_bc <= bx * cx;
                p_ad <= ax * dx;
            end
        end
    end

    // Stage 2: the two sums, brought back to W bits with clipping.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_out  <= 1'b0;
            sum_re <= '0;
            sum_im <= '0;
        end else begin
            v_out <= v1;
            if (v1) begin
                sum_re <= W'(cdiv_pkg::clip_shr(64'(p_ac) + 64'(p_bd), W - 1, W));
                sum_im <= W'(cdiv_pkg::clip_shr(64'(p_bc) - 64'(p_ad), W - 1, W));
            end
        end
    end

endmodule

// File: rtl/cdiv_scale.sv
module cdiv_scale #(
    parameter int unsigned W = cdiv_pkg::CD_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                v_in,
    input  logic signed [W-1:0] sum_re,
    input  logic signed [W-1:0] sum_im,
    input  logic        [W-1:0] scale,
    output logic                v_out,
    output logic signed [W-1:0] res_re,
    output logic signed [W-1:0] res_im
);
    localparam int unsigned PW = 2 * W;

    logic signed [PW-1:0] rx, ix, ex;

    assign rx = {{W{sum_re[W-1]}}, sum_re};
    assign ix = {{W{sum_im[W-1]}}, sum_im};
    assign ex = {{W{scale[W-1]}}, scale};

    // Stage 3: the two scaling multiplies; results hold between valid cycles.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            v_out  <= 1'b0;
            res_re <= '0;
            res_im <= '0;
        end else begin
            v_out <= v_in;
            if (v_in) begin
                res_re <= W'(cdiv_pkg::clip_shr(64'(rx * ex), W - 1, W));
                res_im <= W'(cdiv_pkg::clip_shr(64'(ix * ex), W - 1, W));
            end
        end
    end

endmodule

// File: rtl/mu_cdiv.sv
module mu_cdiv #(
    parameter int unsigned W    = cdiv_pkg::CD_W,
    parameter int unsigned IDXW = cdiv_pkg::CD_IDXW,
    parameter int unsigned MU   = cdiv_pkg::CD_MU
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic [W-1:0] x_re,
    input  logic [W-1:0] x_im,
    input  logic [W-1:0] y_re,
    input  logic [W-1:0] y_im,
    input  logic [W-1:0] y_pow,
    output logic         out_valid,
    output logic [W-1:0] q_re,
    output logic [W-1:0] q_im
);
    logic                v_sum;
    logic signed [W-1:0] s_re;
    logic signed [W-1:0] s_im;
    logic        [W-1:0] e_val;
    logic signed [W-1:0] r_re;
    logic signed [W-1:0] r_im;

    cdiv_cross #(.W(W)) u_cross (
        .clk    (clk),
        .rst_n  (rst_n),
        .v_in   (in_valid),
        .a      ($signed(x_re)),
        .b      ($signed(x_im)),
        .c      ($signed(y_re)),
        .d      ($signed(y_im)),
        .v_out  (v_sum),
        .sum_re (s_re),
        .sum_im (s_im)
    );

    cdiv_recip_rom #(.W(W), .IDXW(IDXW), .MU(MU)) u_rom (
        .clk       (clk),
        .rst_n     (rst_n),
        .pow_in    (y_pow),
        .scale_out (e_val)
    );

    cdiv_scale #(.W(W)) u_scale (
        .clk    (clk),
        .rst_n  (rst_n),
        .v_in   (v_sum),
        .sum_re (s_re),
        .sum_im (s_im),
        .scale  (e_val),
        .v_out  (out_valid),
        .res_re (r_re),
        .res_im (r_im)
    );

    assign q_re = r_re;
    assign q_im = r_im;

endmodule

// File: rtl/cdiv_chk.sv
module cdiv_chk #(
    parameter int unsigned W = cdiv_pkg::CD_W
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] x_re,
    input logic [W-1:0] x_im,
    input logic [W-1:0] y_re,
    input logic [W-1:0] y_im,
    input logic         out_valid,
    input logic [W-1:0] q_re,
    input logic [W-1:0] q_im
);
    logic [1:0] since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= 2'd0;
        end else if (since_rst != 2'd3) begin
            since_rst <= since_rst + 2'd1;
        end
    end

    assert_reset_quiet_R8: assert property (@(posedge clk)
        !rst_n |-> (!out_valid && q_re == '0 && q_im == '0));

    assert_fixed_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3) |-> (out_valid == $past(in_valid, 3)));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst != 2'd0 && !out_valid) |-> ($stable(q_re) && $stable(q_im)));

    assert_zero_num_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && out_valid &&
         $past(in_valid && x_re == '0 && x_im == '0, 3))
        |-> (q_re == '0 && q_im == '0));

    assert_zero_den_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 2'd3 && out_valid &&
         $past(in_valid && y_re == '0 && y_im == '0, 3))
        |-> (q_re == '0 && q_im == '0));

endmodule

bind mu_cdiv cdiv_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .x_re      (x_re),
    .x_im      (x_im),
    .y_re      (y_re),
    .y_im      (y_im),
    .out_valid (out_valid),
    .q_re      (q_re),
    .q_im      (q_im)
);

// File: tb/sim_mu_cdiv.sv
module sim_mu_cdiv;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] x_re = '0, x_im = '0, y_re = '0, y_im = '0, y_pow = '0;
    logic        out_valid;
    logic [15:0] q_re, q_im;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    typedef struct {
        int    re;
        int    im;
        int    cyc;
        string tag;
    } exp_t;

    exp_t sb[$];
    int last_re = 0;
    int last_im = 0;

    mu_cdiv u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im), .y_pow(y_pow),
        .out_valid(out_valid), .q_re(q_re), .q_im(q_im)
    );

    always #5 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int clip16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    // R4 / R5: step-scaled table content.
    function automatic int tbl_model(input int k);
        int q;
        if (k == 0) return 32767;
        q = (164 * 512) / k;
        return (q > 32767) ? 32767 : q;
    endfunction

    // R6: index from bits [14:6], negative maps to entry 0.
    function automatic int idx_model(input int p);
        if (p < 0) return 0;
        return (p >> 6) & 511;
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
        end
    endtask

    // Driver: applies one operand set at a falling edge and pushes the expected result.
    task automatic drive(input int a, input int b, input int c, input int d,
                         input int p, input string tag);
        exp_t it;
        int   e, sr, si;
        e  = tbl_model(idx_model(p));
        sr = clip16((longint'(a) * c + longint'(b) * d) >>> 15);
        si = clip16((longint'(b) * c - longint'(a) * d) >>> 15);
        it.re  = clip16((longint'(sr) * e) >>> 15);
        it.im  = clip16((longint'(si) * e) >>> 15);
        it.cyc = cyc + 3;
        it.tag = tag;
        x_re = 16'(a); x_im = 16'(b); y_re = 16'(c); y_im = 16'(d); y_pow = 16'(p);
        in_valid = 1'b1;
        sb.push_back(it);
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        in_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // Monitor: compares results and checks that idle cycles hold the outputs.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            if (out_valid) begin
                if (sb.size() == 0) begin
                    check(1'b0, "R3 unexpected out_valid", 1, 0);
                end else begin
                    exp_t it;
                    it = sb.pop_front();
                    check($signed(q_re) == it.re, {it.tag, " R1 real"}, $signed(q_re), it.re);
                    check($signed(q_im) == it.im, {it.tag, " R2 imag"}, $signed(q_im), it.im);
                    check(cyc == it.cyc, {it.tag, " R3 latency"}, cyc, it.cyc);
                end
            end else begin
                check($signed(q_re) == last_re && $signed(q_im) == last_im,
                      "R9 hold while idle", $signed(q_re), last_re);
            end
            last_re = $signed(q_re);
            last_im = $signed(q_im);
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R8 out_valid in reset", int'(out_valid), 0);
        check(q_re == '0, "R8 q_re in reset", int'(q_re), 0);
        check(q_im == '0, "R8 q_im in reset", int'(q_im), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R4/R5: sweep every entry, cross sum forced to 32767 so result = e - 1.
        for (int k = 0; k < 512; k++) begin
            drive(-32768, 0, -32768, 0, k << 6, (k < 3) ? "R5 clipped entry" : "R4 entry sweep");
        end
        idle(4);

        // R6: negative power and nonzero low bits.
        drive(-32768, 0, -32768, 0, -1, "R6 negative pow");
        drive(-32768, 0, -32768, 0, -32768, "R6 most negative pow");
        drive(-32768, 0, -32768, 0, (5 << 6) | 63, "R6 low bits ignored");
        drive(-32768, 0, -32768, 0, (3 << 6) | 1, "R5 first unclipped entry");
        idle(3);

        // R7: cross sums clipping both ways.
        drive(-32768, -32768, -32768, -32768, 16384, "R7 positive clip");
        drive(-32768, -32768, 32767, 32767, 16384, "R7 negative clip real");
        drive(32767, -32768, -32768, -32768, 400, "R7 positive clip imag");
        drive(0, 0, 12345, -222, 9000, "R1 zero numerator");
        drive(1000, -2000, 0, 0, 20000, "R2 zero denominator");
        idle(2);

        // R1/R2/R3/R9: random operands with random gaps.
        for (int i = 0; i < 300; i++) begin
            drive(int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768,
                  int'($urandom_range(0, 65535)) - 32768, int'($urandom_range(0, 65535)) - 32768,
                  int'($urandom_range(0, 32767)), "R1 R2 random");
            idle(int'($urandom_range(0, 2)));
        end

        idle(6);
        check(sb.size() == 0, "R3 all results delivered", sb.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog R3 actual=%0d expected=%0d", cyc, 0);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule